// File: doc/BRIEF.md
# Reference-Window Frequency Meter

This block measures the frequency of an unknown oscillator against a reference clock. A controller enables the meter, leaves the mode field at clock-measure, picks one of two monitored inputs, sets a window length in reference cycles and an optional pre-divider, and pulses a start request. The meter opens a gate for the programmed number of reference cycles. It counts edges of the monitored clock while the gate is open, returns the 16-bit result to the reference domain, and drops its busy flag on its own.

The gate travels into the monitored domain through a synchronizer. The end of counting comes back as a toggle that the reference side synchronizes before it captures the frozen count. A window load of 0x1FF gives 512 reference cycles, so with a 26 MHz reference the result reads f_mon x 512 / 26 (f_mon in MHz). A reader polls the busy flag with a bounded number of polls and takes 0 as the result if the flag never clears.

Three states run the reference side. IDLE waits for a qualified start (IDLE to OPEN). OPEN holds the gate high and counts the window down, and moves to DRAIN once the window reaches zero. DRAIN waits for the completion toggle, captures the count and clears the busy flag (DRAIN to IDLE).

Top module: `freq_meter_top`

## Requirements
- R1: After reset, `run` is 0 and `count` is 0.
- R2: A `run_set` pulse while idle, with `meter_en` = 1 and `meter_mode` = 0, makes `run` read 1 from the next reference edge.
- R3: `run_set` has no effect when `meter_en` = 0 or `meter_mode` is not 0: `run` stays 0 and `count` keeps its value.
- R4: The gate stays open for exactly `win_load` + 1 reference cycles. `count` lies within 2 of (win_load+1) x T_ref / (T_mon x (prediv+1)).
- R5: `src_sel` = 0 measures `mon_clk_a`, and `src_sel` = 1 measures `mon_clk_b`. The value is latched at start.
- R6: `prediv` = p makes the meter count one in every p+1 monitored edges. A value of 0 means no division.
- R7: The count saturates at 0xFFFF and does not wrap.
- R8: `run` clears by itself at the end of a measurement. `count` stays unchanged while `run` is 1 and takes the new result on the same edge that clears `run`.
- R9: A `run_set` that arrives while a measurement is in progress, including the capture cycle, is ignored. A request held high restarts the meter one cycle after `run` clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| mon_clk_a | input | 1 | Monitored oscillator, source 0 |
| mon_clk_b | input | 1 | Monitored oscillator, source 1 |
| meter_en | input | 1 | Meter enable; qualifies start requests |
| meter_mode | input | MODE_W | Mode; 0 = clock measure, anything else blocks start |
| src_sel | input | 1 | Monitored source choice |
| run_set | input | 1 | Start request |
| win_load | input | WIN_W | Window length minus one, in reference cycles |
| prediv | input | DIV_W | Pre-divider minus one on the monitored clock |
| run | output | 1 | Busy flag; clears itself when the result is ready |
| count | output | CNT_W | Last measured edge count |

## Verification
Two events can fall in the same reference cycle: capturing a finished result, which clears `run`, and receiving a new start request. The bench provokes this by holding `run_set` high through the whole of a short measurement. It then expects `run` to read 0 at exactly one sample point, with a correct result in `count`, and to read 1 again at the next sample. A second request pulsed in the middle of an open window must leave the measured count matching the original window length.

// File: rtl/fm_pkg.sv
package fm_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_OPEN  = 2'd1,
        ST_DRAIN = 2'd2
    } fm_state_e;

    localparam int MODE_CLK_MEASURE = 0;
endpackage

// File: rtl/fm_sync.sv
module fm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/fm_mon_counter.sv
module fm_mon_counter #(
    parameter int CNT_W = 16,
    parameter int DIV_W = 8
) (
    input  logic             mon_clk,
    input  logic             rst_n,
    input  logic             gate_ref,
    input  logic [DIV_W-1:0] div_lim,
    output logic [CNT_W-1:0] edge_cnt,
    output logic             done_tgl
);
    logic             gate_s;
    logic             gate_d;
    logic             gate_rise;
    logic             gate_fall;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_base;
    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] div_base;

    fm_sync #(.STAGES(2)) u_gate_sync (
        .clk  (mon_clk),
        .rst_n(rst_n),
        .d    (gate_ref),
        .q    (gate_s)
    );

    assign gate_rise = gate_s && !gate_d;
    assign gate_fall = !gate_s && gate_d;
    assign cnt_base  = gate_rise ? '0 : cnt_q;
    assign div_base  = gate_rise ? '0 : div_q;

    always_ff @(posedge mon_clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_d   <= 1'b0;
            cnt_q    <= '0;
            div_q    <= '0;
            done_tgl <= 1'b0;
        end else begin
            gate_d <= gate_s;
            if (gate_s) begin
                if (div_base == div_lim) begin
                    div_q <= '0;
                    if (cnt_base != {CNT_W{1'b1}})
                        cnt_q <= cnt_base + 1'b1;
                    else
                        cnt_q <= cnt_base;
                end else begin
                    div_q <= div_base + 1'b1;
                    cnt_q <= cnt_base;
                end
            end
            if (gate_fall)
                done_tgl <= ~done_tgl;
        end
    end

    assign edge_cnt = cnt_q;

    AST_SAT_HOLD: assert property (@(posedge mon_clk) disable iff (!rst_n)
        (cnt_q == {CNT_W{1'b1}} && gate_s && gate_d) |=> (cnt_q == {CNT_W{1'b1}})); // R7

    AST_FROZEN_AFTER_GATE: assert property (@(posedge mon_clk) disable iff (!rst_n)
        (!gate_s && !gate_d) |=> $stable(cnt_q)); // R8
endmodule

// File: rtl/fm_ref_ctrl.sv
module fm_ref_ctrl
    import fm_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int WIN_W  = 10,
    parameter int DIV_W  = 8,
    parameter int MODE_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              meter_en,
    input  logic [MODE_W-1:0] meter_mode,
    input  logic              src_sel,
    input  logic              run_set,
    input  logic [WIN_W-1:0]  win_load,
    input  logic [DIV_W-1:0]  prediv,
    input  logic              done_sync,
    input  logic [CNT_W-1:0]  mon_cnt,
    output logic              gate,
    output logic              sel_l,
    output logic [DIV_W-1:0]  div_l,
    output logic              run,
    output logic [CNT_W-1:0]  count
);
    fm_state_e        state_q;
    fm_state_e        state_d;
    logic [WIN_W-1:0] win_q;
    logic [WIN_W-1:0] win_l;
    logic [WIN_W:0]   gate_len;
    logic             ack_seen;
    logic             ack_pend;
    logic             start_ok;

    assign start_ok = run_set && meter_en && (meter_mode == MODE_W'(MODE_CLK_MEASURE));
    assign ack_pend = done_sync != ack_seen;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_ok)     state_d = ST_OPEN;
            ST_OPEN:  if (win_q == '0)  state_d = ST_DRAIN;
            ST_DRAIN: if (ack_pend)     state_d = ST_IDLE;
            default:                    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q    <= '0;
            win_l    <= '0;
            gate_len <= '0;
            gate     <= 1'b0;
            sel_l    <= 1'b0;
            div_l    <= '0;
            run      <= 1'b0;
            count    <= '0;
            ack_seen <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_ok) begin
                        win_q    <= win_load;
                        win_l    <= win_load;
                        gate_len <= (WIN_W+1)'(1);
                        sel_l    <= src_sel;
                        div_l    <= prediv;
                        gate     <= 1'b1;
                        run      <= 1'b1;
                    end
                end
                ST_OPEN: begin
                    if (win_q == '0) begin
                        gate <= 1'b0;
                    end else begin
                        win_q    <= win_q - 1'b1;
                        gate_len <= gate_len + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (ack_pend) begin
                        count    <= mon_cnt;
                        ack_seen <= done_sync;
                        run      <= 1'b0;
                    end
                end
                default: run <= 1'b0;
            endcase
        end
    end

    AST_START_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run) |-> ($past(meter_en) && $past(meter_mode) == MODE_W'(MODE_CLK_MEASURE))); // R3

    AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OPEN && win_q == '0) |-> (gate_len == ({1'b0, win_l} + 1'b1))); // R4

    AST_COUNT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && $past(run)) |-> $stable(count)); // R8

    AST_GATE_IN_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        gate |-> run); // R8

    AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(gate) |-> ($past(state_q) == ST_IDLE)); // R9
endmodule

// File: rtl/freq_meter_top.sv
module freq_meter_top #(
    parameter int CNT_W  = 16,
    parameter int WIN_W  = 10,
    parameter int DIV_W  = 8,
    parameter int MODE_W = 2
) (
    input  logic              ref_clk,
    input  logic              rst_n,
    input  logic              mon_clk_a,
    input  logic              mon_clk_b,
    input  logic              meter_en,
    input  logic [MODE_W-1:0] meter_mode,
    input  logic              src_sel,
    input  logic              run_set,
    input  logic [WIN_W-1:0]  win_load,
    input  logic [DIV_W-1:0]  prediv,
    output logic              run,
    output logic [CNT_W-1:0]  count
);
    logic             gate;
    logic             sel_l;
    logic [DIV_W-1:0] div_l;
    logic             mon_clk;
    logic [CNT_W-1:0] mon_cnt;
    logic             done_tgl;
    logic             done_sync;

    // source is latched at start and only changes while the gate is shut
    assign mon_clk = sel_l ? mon_clk_b : mon_clk_a;

    fm_ref_ctrl #(
        .CNT_W(CNT_W), .WIN_W(WIN_W), .DIV_W(DIV_W), .MODE_W(MODE_W)
    ) u_ctrl (
        .clk       (ref_clk),
        .rst_n     (rst_n),
        .meter_en  (meter_en),
        .meter_mode(meter_mode),
        .src_sel   (src_sel),
        .run_set   (run_set),
        .win_load  (win_load),
        .prediv    (prediv),
        .done_sync (done_sync),
        .mon_cnt   (mon_cnt),
        .gate      (gate),
        .sel_l     (sel_l),
        .div_l     (div_l),
        .run       (run),
        .count     (count)
    );

    fm_mon_counter #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_mon (
        .mon_clk (mon_clk),
        .rst_n   (rst_n),
        .gate_ref(gate),
        .div_lim (div_l),
        .edge_cnt(mon_cnt),
        .done_tgl(done_tgl)
    );

    fm_sync #(.STAGES(2)) u_done_sync (
        .clk  (ref_clk),
        .rst_n(rst_n),
        .d    (done_tgl),
        .q    (done_sync)
    );
endmodule

// File: tb/sim_freq_meter_top.sv
`timescale 1ns/1ps
module sim_freq_meter_top;
    localparam int WIN_W = 14;
    localparam real T_REF = 20.0;
    localparam real T_A   = 4.0;
    localparam real T_B   = 6.0;

    logic        ref_clk = 0, mon_clk_a = 0, mon_clk_b = 0;
    logic        rst_n = 0;
    logic        meter_en = 0, src_sel = 0, run_set = 0;
    logic [1:0]  meter_mode = 0;
    logic [WIN_W-1:0] win_load = 0;
    logic [7:0]  prediv = 0;
    logic        run;
    logic [15:0] count;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #10 ref_clk = ~ref_clk;
    always #2  mon_clk_a = ~mon_clk_a;
    always #3  mon_clk_b = ~mon_clk_b;

    freq_meter_top #(.WIN_W(WIN_W)) u0 (
        .ref_clk(ref_clk), .rst_n(rst_n), .mon_clk_a(mon_clk_a), .mon_clk_b(mon_clk_b),
        .meter_en(meter_en), .meter_mode(meter_mode), .src_sel(src_sel),
        .run_set(run_set), .win_load(win_load), .prediv(prediv),
        .run(run), .count(count)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic real expect_cnt(input int win, input int p, input bit s);
        return (win + 1) * T_REF / ((s ? T_B : T_A) * (p + 1));
    endfunction

    task automatic check_cnt(input string req, input int c, input real e);
        check((real'(c) >= e - 2.0) && (real'(c) <= e + 2.0), req, c, int'(e));
    endtask

    // bounded poll; result 0 when run never clears
    task automatic poll_done(input int step, output int res);
        logic [15:0] prev;
        bit moved;
        prev = count;
        moved = 0;
        for (int i = 0; i < 10000; i++) begin
            repeat (step) @(negedge ref_clk);
            if (!run) break;
            if (count != prev) moved = 1;
        end
        check(!moved, "R8 count stable while run", int'(moved), 0);
        check(!run, "R8 run self-clears", int'(run), 0);
        res = run ? 0 : int'(count);
    endtask

    task automatic measure(input bit s, input int p, input int win, input int step,
                           input bit poke, output int res);
        @(negedge ref_clk);
        src_sel = s; prediv = 8'(p); win_load = WIN_W'(win);
        meter_en = 1; meter_mode = 0; run_set = 1;
        @(negedge ref_clk);
        run_set = 0;
        check(run === 1'b1, "R2 run set by start", int'(run), 1);
        if (poke) begin
            repeat (40) @(negedge ref_clk);
            run_set = 1;
            @(negedge ref_clk);
            run_set = 0;
        end
        poll_done(step, res);
        meter_en = 0;
    endtask

    initial begin
        int r;
        logic [15:0] held;
        repeat (3) @(negedge ref_clk);
        check(run === 1'b0, "R1 run after reset", int'(run), 0);
        check(count === 16'h0, "R1 count after reset", int'(count), 0);
        rst_n = 1;
        repeat (2) @(negedge ref_clk);

        // R3: enable low
        win_load = 14'h0F; meter_en = 0; meter_mode = 0; run_set = 1;
        @(negedge ref_clk); run_set = 0;
        @(negedge ref_clk);
        check(run === 1'b0, "R3 start ignored without enable", int'(run), 0);
        check(count === 16'h0, "R3 count untouched (enable)", int'(count), 0);
        // R3: mode nonzero
        meter_en = 1; meter_mode = 2'd1; run_set = 1;
        @(negedge ref_clk); run_set = 0;
        @(negedge ref_clk);
        check(run === 1'b0, "R3 start ignored with mode 1", int'(run), 0);
        meter_mode = 2'd3; run_set = 1;
        @(negedge ref_clk); run_set = 0;
        @(negedge ref_clk);
        check(run === 1'b0, "R3 start ignored with mode 3", int'(run), 0);
        check(count === 16'h0, "R3 count untouched (mode)", int'(count), 0);
        meter_mode = 0; meter_en = 0;

        // R4 R5 R6 sweep
        for (int s = 0; s < 2; s++)
            for (int p = 0; p < 4; p++)
                for (int w = 0; w < 3; w++) begin
                    int win;
                    win = (w == 0) ? 'h0F : (w == 1) ? 'h3F : 'h1FF;
                    measure(s[0], p, win, 1, 0, r);
                    check_cnt($sformatf("R4 R5 R6 src=%0d prediv=%0d win=%0d", s, p, win),
                              r, expect_cnt(win, p, s[0]));
                end

        // R9: request during open window is ignored
        measure(0, 0, 'hFF, 1, 1, r);
        check_cnt("R9 mid-window request ignored", r, expect_cnt('hFF, 0, 0));

        // R7: saturation
        measure(0, 0, 'h3FFF, 4, 0, r);
        check(r == 'hFFFF, "R7 saturates", r, 'hFFFF);
        held = count;
        // R3 after saturation: ignored request keeps result
        run_set = 1; meter_en = 0;
        @(negedge ref_clk); run_set = 0;
        @(negedge ref_clk);
        check(count === held && run === 1'b0, "R3 result kept", int'(count), int'(held));

        // R9: start held through capture cycle
        @(negedge ref_clk);
        src_sel = 1; prediv = 0; win_load = 14'h0F; meter_en = 1; meter_mode = 0; run_set = 1;
        @(negedge ref_clk);
        for (int i = 0; i < 1000 && run; i++) @(negedge ref_clk);
        check(run === 1'b0, "R9 run clears once", int'(run), 0);
        check_cnt("R8 result at clear", int'(count), expect_cnt('h0F, 0, 1));
        @(negedge ref_clk);
        check(run === 1'b1, "R9 held request restarts next cycle", int'(run), 1);
        run_set = 0;
        poll_done(1, r);
        check_cnt("R9 restarted measurement", r, expect_cnt('h0F, 0, 1));

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge ref_clk);
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule